// File: doc/BRIEF.md
# Streaming zero-insertion upsampler

This block raises the sample rate of a stream of two's-complement samples by a fixed integer factor L. Every sample it accepts becomes L output samples. The real value sits in one slot chosen by an elaboration-time offset, and every other slot carries the all-zero word. The result is the usual front end ahead of an interpolation (anti-imaging) filter, which is not part of this block.

Two output formats are selectable at elaboration. In scalar mode one output sample leaves per cycle, so one input produces L consecutive output beats. In vector mode with input spacing S, where S divides L, each output beat packs L/S lanes and one input produces S beats. Lane 0 holds the earliest sample in time. In both modes the sample at overall position p is found in beat p / LANES, lane p % LANES.

A ready output drops while a sequence is still being emitted, so a source that follows it can never break the minimum input spacing. A local synchronous clear abandons any sequence in progress.

Top module: `zero_upsampler`

## Requirements
- R1: After an input is accepted at a clock edge, out_valid is high on the next BEATS consecutive cycles. BEATS is L in scalar mode and SPACING in vector mode.
- R2: Scalar mode: among the L output beats of one input, beat number OFFSET (counting from 0) carries the input value and all other beats carry zero.
- R3: While in_valid is low, in_data has no effect, and out_valid stays low once any pending beats are done.
- R4: in_ready is low for exactly BEATS-1 cycles after an acceptance. An input presented while in_ready is low is ignored and does not change the output sequence.
- R5: When in_valid is held high, inputs are accepted every BEATS cycles and out_valid stays high without gaps.
- R6: srst high at a clock edge clears the sequence in progress and takes priority over in_valid. On the next cycle out_valid is 0 and in_ready is 1.
- R7: out_data is all zeros whenever out_valid is low.
- R8: Vector mode: each beat carries L/SPACING lanes of W bits, lane j at bits [j*W +: W]. Sample position b*LANES+j equals OFFSET only in the lane that holds the input value.
- R9: While rst_n is low and after it is released, out_valid is 0, out_data is 0 and in_ready is 1 until the first acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous clear of the datapath (tie low if unused) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W | Input sample, two's complement |
| in_ready | output | 1 | High when an input will be accepted at the next edge |
| out_valid | output | 1 | Output beat strobe |
| out_data | output | LANES*W | Output beat, lane 0 in the low bits |

## Verification
Each result is due one edge after its cause. The first beat of a sequence appears in the cycle after the accepting edge, in_ready falls in that same cycle, and a clear shows in the cycle after the edge where srst was sampled. The bench has a behavioural model that pushes all beats of an accepted sample into a queue and pops one beat per edge. It updates at the rising edge and compares every output at the falling edge, so each comparison sees exactly one register stage after the stimulus. Inputs also change at the falling edge, which keeps them stable across the rising edge that samples them.

// File: rtl/zero_upsampler.sv
module zero_upsampler #(
  parameter int W       = 16,
  parameter int L       = 4,
  parameter int OFFSET  = 0,
  parameter bit VEC_OUT = 1'b0,
  parameter int SPACING = 1,
  localparam int BEATS  = VEC_OUT ? SPACING : L,
  localparam int LANES  = L / BEATS,
  localparam int SW     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               in_valid,
  input  logic [W-1:0]       in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [LANES*W-1:0] out_data
);

  localparam logic [SW-1:0] LAST = SW'(BEATS - 1);

  logic [SW-1:0]      beat, cur;
  logic [W-1:0]       hold, src;
  logic [LANES*W-1:0] nxt_data;
  logic               busy, accept, emit;

  assign busy     = (beat != '0);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign emit     = accept || busy;
  assign cur      = accept ? '0 : beat;
  assign src      = accept ? in_data : hold;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign nxt_data[j*W +: W] =
      (emit && (int'(cur) * LANES + j == OFFSET)) ? src : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat      <= '0;
      hold      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (srst) begin
      beat      <= '0;
      hold      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) hold <= in_data;
      beat      <= (emit && cur != LAST) ? cur + SW'(1) : '0;
      out_valid <= emit;
      out_data  <= nxt_data;
    end
  end

  initial begin
    a_offset_range_r2: assert (OFFSET >= 0 && OFFSET < L)
      else $error("OFFSET out of range");
    a_spacing_divides_r8: assert (!VEC_OUT || (SPACING >= 1 && L % SPACING == 0))
      else $error("SPACING must divide L");
  end

  p_accept_emits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !srst) |=> out_valid);

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !srst) |=> (in_ready == (BEATS == 1)));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!out_valid && in_ready));

  p_zero_when_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

endmodule

// File: tb/test_zero_upsampler.sv
module upsampler_model #(
  parameter int W = 12, parameter int L = 4, parameter int OFFSET = 0,
  parameter bit VEC_OUT = 1'b0, parameter int SPACING = 1,
  localparam int BEATS = VEC_OUT ? SPACING : L,
  localparam int LANES = L / BEATS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               in_valid,
  input  logic [W-1:0]       in_data,
  output logic               exp_valid,
  output logic               exp_ready,
  output logic [LANES*W-1:0] exp_data
);
  logic [LANES*W-1:0] q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst) begin
      q.delete();
      exp_valid = 1'b0;
      exp_ready = 1'b1;
      exp_data  = '0;
    end else begin
      if (in_valid && exp_ready)
        for (int b = 0; b < BEATS; b++) begin
          logic [LANES*W-1:0] v;
          v = '0;
          for (int j = 0; j < LANES; j++)
            if (b * LANES + j == OFFSET) v[j*W +: W] = in_data;
          q.push_back(v);
        end
      if (q.size() > 0) begin
        exp_data  = q.pop_front();
        exp_valid = 1'b1;
      end else begin
        exp_data  = '0;
        exp_valid = 1'b0;
      end
      exp_ready = (q.size() == 0);
    end
  end
endmodule

module test_zero_upsampler;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srst = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;

  logic s_ready, s_valid, s_eready, s_evalid;
  logic [W-1:0] s_data, s_edata;
  logic v_ready, v_valid, v_eready, v_evalid;
  logic [3*W-1:0] v_data, v_edata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  always #4 clk = ~clk;

  zero_upsampler #(.W(W), .L(4), .OFFSET(2), .VEC_OUT(1'b0), .SPACING(1)) i_zero_upsampler (
    .clk(clk), .rst_n(rst_n), .srst(srst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(s_ready), .out_valid(s_valid), .out_data(s_data));

  zero_upsampler #(.W(W), .L(6), .OFFSET(4), .VEC_OUT(1'b1), .SPACING(2)) i_zero_upsampler_vec (
    .clk(clk), .rst_n(rst_n), .srst(srst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(v_ready), .out_valid(v_valid), .out_data(v_data));

  upsampler_model #(.W(W), .L(4), .OFFSET(2), .VEC_OUT(1'b0), .SPACING(1)) m_scalar (
    .clk(clk), .rst_n(rst_n), .srst(srst), .in_valid(in_valid), .in_data(in_data),
    .exp_valid(s_evalid), .exp_ready(s_eready), .exp_data(s_edata));

  upsampler_model #(.W(W), .L(6), .OFFSET(4), .VEC_OUT(1'b1), .SPACING(2)) m_vec (
    .clk(clk), .rst_n(rst_n), .srst(srst), .in_valid(in_valid), .in_data(in_data),
    .exp_valid(v_evalid), .exp_ready(v_eready), .exp_data(v_edata));

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "scalar out_valid", 64'(s_valid), 64'(s_evalid));
      chk(cur_req == "R3" || cur_req == "R9" ? cur_req : "R4", "scalar in_ready", 64'(s_ready), 64'(s_eready));
      chk(cur_req == "R9" ? "R9" : "R2", "scalar out_data", 64'(s_data), 64'(s_edata));
      chk(cur_req, "vector out_valid", 64'(v_valid), 64'(v_evalid));
      chk(cur_req == "R9" ? "R9" : "R4", "vector in_ready", 64'(v_ready), 64'(v_eready));
      chk("R8", "vector out_data", 64'(v_data), 64'(v_edata));
      if (!s_valid) chk("R7", "scalar idle data", 64'(s_data), 64'd0);
      if (!v_valid) chk("R7", "vector idle data", 64'(v_data), 64'd0);
    end
  end

  task automatic drive(bit v, logic [W-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, W'($urandom));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    // R9: reset state held and just after release
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1: single sample, beats follow the accepting edge
    cur_req = "R1";
    drive(1'b1, 12'h5a5);
    idle(7);
    // R2: placement of extreme values
    cur_req = "R2";
    drive(1'b1, 12'hfff);
    idle(7);
    drive(1'b1, 12'h800);
    idle(7);
    drive(1'b1, 12'h7ff);
    idle(7);
    // R5: valid held high, gapless output
    cur_req = "R5";
    for (int i = 0; i < 16; i++) drive(1'b1, W'($urandom));
    idle(7);
    // R4: pulses every second cycle, scalar ignores those while busy
    cur_req = "R4";
    for (int i = 0; i < 12; i++) drive(i[0] == 1'b0, W'($urandom));
    idle(7);
    // R3: garbage data with valid low
    cur_req = "R3";
    idle(10);
    // R6: clear mid-sequence, clear with valid high, clear while idle
    cur_req = "R6";
    drive(1'b1, 12'h123);
    drive(1'b0, 12'h000);
    srst = 1'b1;
    drive(1'b1, 12'h456);
    srst = 1'b0;
    idle(2);
    drive(1'b1, 12'h321);
    srst = 1'b1;
    drive(1'b0, 12'h0);
    srst = 1'b0;
    idle(7);
    // mixed traffic with occasional clears
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      srst = ($urandom % 40) == 0;
      drive(($urandom % 2) == 1, W'($urandom));
    end
    srst = 1'b0;
    idle(8);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R1 watchdog got timeout exp completion");
      summary();
    end
  end
endmodule